// File: doc/BRIEF.md
# Frequency and Pulse-Width Measurement Unit

This block measures an asynchronous reference signal by counting cycles of its own clock, the target clock. In frequency mode it counts target cycles across a window of 2^N reference periods. Reading the result and dividing by 2^N gives the reference period in target cycles, so software can work out either clock's frequency from the other. In pulse-width mode it counts the target cycles that make up one high phase or one low phase of the reference.

Software controls the unit through one 32-bit location. A write starts a measurement, or aborts one and clears the result. A read returns a busy flag and the running or final count. The reference input passes through a synchronizer into the target clock domain, and its edges are found there. The count saturates instead of wrapping.

Top module: `freq_pulse_meter`

## Requirements
- R1: After reset the read word is zero: busy (bit 31) is 0 and the count (bits 30:0) is 0.
- R2: A write with bit 31 = 1 starts a measurement. From the next cycle the read shows busy = 1 and count = 0, and no counting happens until the selected start edge of the reference is detected.
- R3: Frequency mode is selected by write bit 8 = 0, with the scale N in write bits 4:0. Counting starts at the first reference rising edge after the start write and ends at the 2^N-th rising edge after that. For a reference with a period of P target cycles, the final count is 2^N * P.
- R4: Pulse mode is selected by write bit 8 = 1. With write bit 9 = 0, counting starts on a reference rising edge and stops on the next falling edge. The final count equals the high phase length in target cycles.
- R5: Pulse mode with write bit 9 = 1 starts on a falling edge and stops on the next rising edge. The final count equals the low phase length in target cycles.
- R6: A start write during a running measurement discards that measurement. The count returns to 0 and a new measurement runs with the newly written settings.
- R7: A write with bit 31 = 0 sets busy to 0 and the count to 0 in the next cycle, whether a measurement was running or the unit was idle.
- R8: When a measurement ends, busy drops to 0. The final count then stays unchanged while there are no writes, whatever the reference input does.
- R9: The count saturates at its all-ones value (parameter CNT_W bits wide, zero-extended into bits 30:0) and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock; all logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference signal, asynchronous to clk |
| wr_en | input | 1 | Control write strobe, one cycle |
| wr_data | input | 32 | Control word: scale 4:0, mode 8, polarity 9, start/abort 31 |
| rd_data | output | 32 | Status word: count 30:0, busy 31 |

## Verification
A wrong phase register shows up as a count that is off by whole reference periods, or as busy never falling, and this is visible at the end of the first measurement. A window comparison that is off by one shows up as a count off by exactly P. A start or end edge that uses the wrong polarity measures the opposite phase, and the bench catches this because it uses unequal high and low lengths. Errors in abort, restart and hold logic show on the cycle after the write, because every control write takes effect on the next edge.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARM  = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    localparam int GO_BIT   = 31;
    localparam int MODE_BIT = 8;
    localparam int POL_BIT  = 9;
endpackage

// File: rtl/fpm_edge_sync.sv
module fpm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise =  chain_q[STAGES-1] & ~prev_q;
    assign fall = ~chain_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/fpm_sat_inc.sv
module fpm_sat_inc #(
    parameter int W = 31
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] next_val
);
    always_comb begin
        if (&val) next_val = val;
        else      next_val = val + W'(1);
    end
endmodule

// File: rtl/fpm_core.sv
module fpm_core
    import fpm_pkg::*;
#(
    parameter int CNT_W   = 31,
    parameter int SCALE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise,
    input  logic               fall,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic               busy,
    output logic [CNT_W-1:0]   count
);
    localparam int REF_W = 1 << SCALE_W;

    typedef struct packed {
        phase_e               phase;
        logic                 busy;
        logic                 pulse;
        logic                 low;
        logic [SCALE_W-1:0]   scale;
        logic [REF_W-1:0]     ref_cnt;
        logic [CNT_W-1:0]     tgt_cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] tgt_inc;
    logic [REF_W-1:0] window;
    logic             start_hit, stop_hit;

    fpm_sat_inc #(.W(CNT_W)) u_inc (
        .val      (st_q.tgt_cnt),
        .next_val (tgt_inc)
    );

    always_comb begin
        st_d      = st_q;
        window    = REF_W'(1) << st_q.scale;
        start_hit = st_q.pulse ? (st_q.low ? fall : rise) : rise;
        stop_hit  = st_q.pulse ? (st_q.low ? rise : fall) : 1'b0;

        case (st_q.phase)
            PH_ARM: begin
                if (start_hit) begin
                    st_d.phase   = PH_RUN;
                    st_d.ref_cnt = '0;
                    st_d.tgt_cnt = '0;
                end
            end
            PH_RUN: begin
                st_d.tgt_cnt = tgt_inc;
                if (!st_q.pulse) begin
                    if (rise) begin
                        if (st_q.ref_cnt + REF_W'(1) == window) begin
                            st_d.phase = PH_IDLE;
                            st_d.busy  = 1'b0;
                        end else begin
                            st_d.ref_cnt = st_q.ref_cnt + REF_W'(1);
                        end
                    end
                end else if (stop_hit) begin
                    st_d.phase = PH_IDLE;
                    st_d.busy  = 1'b0;
                end
            end
            default: ;
        endcase

        if (wr_en) begin
            st_d.tgt_cnt = '0;
            st_d.ref_cnt = '0;
            if (wr_data[GO_BIT]) begin
                st_d.phase = PH_ARM;
                st_d.busy  = 1'b1;
                st_d.pulse = wr_data[MODE_BIT];
                st_d.low   = wr_data[POL_BIT];
                st_d.scale = wr_data[SCALE_W-1:0];
            end else begin
                st_d.phase = PH_IDLE;
                st_d.busy  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = st_q.busy;
    assign count = st_q.tgt_cnt;
endmodule

// File: rtl/freq_pulse_meter.sv
module freq_pulse_meter #(
    parameter int CNT_W       = 31,
    parameter int SCALE_W     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_in,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);
    logic             ref_rise, ref_fall;
    logic             busy;
    logic [CNT_W-1:0] count;
    logic [30:0]      count_ext;

    fpm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_in),
        .rise     (ref_rise),
        .fall     (ref_fall)
    );

    fpm_core #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (ref_rise),
        .fall    (ref_fall),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .busy    (busy),
        .count   (count)
    );

    assign count_ext = 31'(count);
    assign rd_data   = {busy, count_ext};
endmodule

// File: rtl/freq_pulse_meter_checker.sv
module freq_pulse_meter_checker #(
    parameter int CNT_W = 31
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data
);
    logic [CNT_W-1:0] cnt;
    assign cnt = rd_data[CNT_W-1:0];

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31]) |=> (rd_data[31] && rd_data[30:0] == 31'd0));

    assert_abort_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[31]) |=> (rd_data == 32'd0));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[31] && !wr_en) |=> $stable(rd_data));

    assert_count_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31] && !wr_en) |=> (rd_data[30:0] >= $past(rd_data[30:0])));

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt) && !wr_en) |=> (&cnt));
endmodule

bind freq_pulse_meter freq_pulse_meter_checker #(.CNT_W(CNT_W)) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/freq_pulse_meter_test.sv
`timescale 1ns/1ps
module freq_pulse_meter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data, rd_sat;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    freq_pulse_meter uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    freq_pulse_meter #(.CNT_W(8)) uut_sat (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_sat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 32'd0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            if (!rd_data[31]) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] ctl(input bit go, input bit pulse, input bit low, input int n);
        return {go, 21'd0, 1'b0, 1'b0} | (32'(low) << 9) | (32'(pulse) << 8) | 32'(n[4:0]) | (32'(go) << 31);
    endfunction

    task automatic set_ref(input logic v);
        @(negedge clk);
        ref_in = v;
        cycles(5);
    endtask

    initial begin
        cycles(400000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cycles(3);
        check("R1 reset", rd_data, 32'd0);
        rst_n = 1'b1;
        cycles(2);
        check("R1 after release", rd_data, 32'd0);

        // R3: frequency sweep over scale and period
        for (int n = 0; n <= 4; n++) begin
            for (int p = 2; p <= 7; p++) begin
                set_ref(1'b0);
                write(ctl(1, 0, 0, n));
                check("R2 busy set, count zero", rd_data, 32'h8000_0000);
                cycles(3);
                check("R2 no count before edge", rd_data, 32'h8000_0000);
                for (int k = 0; k <= (1 << n); k++) begin
                    ref_in = 1'b1;
                    cycles(1);
                    ref_in = 1'b0;
                    cycles(p - 1);
                end
                wait_done();
                check("R3 frequency count", rd_data, 32'((1 << n) * p));
            end
        end

        // R4 / R5: pulse width sweep
        for (int h = 1; h <= 20; h++) begin
            set_ref(1'b0);
            write(ctl(1, 1, 0, 0));
            ref_in = 1'b1; cycles(h);
            ref_in = 1'b0; cycles(h + 3);
            wait_done();
            check("R4 high phase", rd_data, 32'(h));
            set_ref(1'b1);
            write(ctl(1, 1, 1, 0));
            ref_in = 1'b0; cycles(h + 2);
            ref_in = 1'b1; cycles(4);
            wait_done();
            check("R5 low phase", rd_data, 32'(h + 2));
        end

        // R8: final count holds while reference toggles
        set_ref(1'b0);
        write(ctl(1, 1, 0, 0));
        ref_in = 1'b1; cycles(9);
        ref_in = 1'b0; cycles(5);
        wait_done();
        for (int k = 0; k < 6; k++) begin
            ref_in = ~ref_in;
            cycles(3);
        end
        cycles(4);
        check("R8 hold after done", rd_data, 32'd9);

        // R7: idle abort clears result
        write(32'd0);
        check("R7 idle abort", rd_data, 32'd0);

        // R7: abort mid-run
        set_ref(1'b0);
        write(ctl(1, 0, 0, 4));
        for (int k = 0; k < 3; k++) begin
            ref_in = 1'b1; cycles(1);
            ref_in = 1'b0; cycles(4);
        end
        write(32'd0);
        check("R7 running abort", rd_data, 32'd0);
        for (int k = 0; k < 3; k++) begin
            ref_in = 1'b1; cycles(1);
            ref_in = 1'b0; cycles(4);
        end
        check("R7 stays idle after abort", rd_data, 32'd0);

        // R6: restart mid-run with new settings
        write(ctl(1, 0, 0, 4));
        for (int k = 0; k < 3; k++) begin
            ref_in = 1'b1; cycles(1);
            ref_in = 1'b0; cycles(4);
        end
        cycles(3);
        write(ctl(1, 1, 0, 0));
        check("R6 restart clears count", rd_data, 32'h8000_0000);
        ref_in = 1'b1; cycles(6);
        ref_in = 1'b0; cycles(5);
        wait_done();
        check("R6 new measurement", rd_data, 32'd6);

        // R9: saturation in narrow instance
        set_ref(1'b0);
        write(ctl(1, 1, 0, 0));
        ref_in = 1'b1; cycles(300);
        ref_in = 1'b0; cycles(5);
        wait_done();
        check("R9 wide count", rd_data, 32'd300);
        check("R9 saturated", rd_sat, 32'd255);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule